// File: doc/BRIEF.md
# Flash Bus Operation Decoder

This block sits behind the pins of an asynchronous parallel flash device. It samples the chip-enable, output-enable, write-enable, device-reset and width-strap inputs into the system clock domain through a short synchroniser. On every cycle it classifies them into exactly one bus operation: reset, standby, output-disable, read or write. The classification drives a five-state machine. The current state decides whether the 16-bit data bus is driven and which array access or command strobe is raised.

The width strap (`wide`) has two effects. When it is high the bus is 16 bits wide and the address is the 20 address pins. When it is low only the low eight data pins carry data, and data pin 15 becomes the least-significant address input. That extra bit selects the low or high byte of the addressed word. Reads present that byte on pins 7..0. Writes pass the byte to the command block together with the lane it targets.

A write is handed on when its strobe ends: the first cycle in which the synchronised controls stop decoding as a write. The block then emits a single-cycle strobe, with the address and data of the last synchronised write sample, to the command logic. A read raises a request to the array with the word address. It returns the array's answer on the bus.

Top module: `flash_bus_decoder`

States and transitions: `OP_RESET` (code 0), `OP_STANDBY` (1), `OP_DISABLE` (2), `OP_READ` (3) and `OP_WRITE` (4). The next state is always the decode of the current synchronised controls, so every state can move to every other. Two transitions have side effects. `OP_WRITE` to any state except `OP_RESET` fires the command strobe. Any state to `OP_RESET` discards a pending write. The system reset `rst_n` forces `OP_RESET`.

## Requirements
- R1: With `prst_n` low the state is `OP_RESET` (op code 0), whatever the other controls are. `dq_oe` is 0 and `rd_req` is low.
- R2: With `ce_n`=0, `oe_n`=0, `we_n`=1 and `prst_n`=1 in word mode (`wide`=1), the state is `OP_READ` (code 3). `rd_req` is high, `dq_oe` is 16'hFFFF and `dq_out` equals `rd_data`, with `rd_addr` equal to the address pins.
- R3: With `ce_n`=0, `oe_n`=1, `we_n`=0 and `prst_n`=1, the state is `OP_WRITE` (code 4) and `dq_oe` is 0. When the write ends, `cmd_stb` pulses once. `cmd_addr` and `cmd_data` then hold the address pins and data pins of that write.
- R4: With `ce_n`=0 and both `oe_n` and `we_n` high, or both low, the state is `OP_DISABLE` (code 2). `dq_oe` is 0, and no read request or command strobe is made.
- R5: With `ce_n`=1 and `prst_n`=1, the state is `OP_STANDBY` (code 1) and `dq_oe` is 0, whatever `oe_n` and `we_n` are.
- R6: In byte mode (`wide`=0), a read drives `dq_oe`=16'h00FF. Data pin 15 is read as the low address bit: 0 puts `rd_data[7:0]` on `dq_out[7:0]`, and 1 puts `rd_data[15:8]` there. `dq_out[15:8]` is 0.
- R7: In byte mode, a write delivers `cmd_data`={8'h00, data pins 7..0}, `cmd_byte`=1 and `cmd_upper` equal to data pin 15. In word mode `cmd_byte` and `cmd_upper` are 0.
- R8: `cmd_stb` is high for exactly one cycle per completed write. A write ended by `prst_n` going low produces no strobe.
- R9: A change on the pins appears in `op` exactly SYNC_STAGES+1 clock edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | System reset, active low |
| ce_n | input | 1 | Chip enable pin, active low |
| oe_n | input | 1 | Output enable pin, active low |
| we_n | input | 1 | Write enable pin, active low |
| prst_n | input | 1 | Device reset pin, active low |
| wide | input | 1 | Width strap: 1 word mode, 0 byte mode |
| addr | input | AW (20) | Address pins |
| dq_in | input | DW (16) | Data pins, input side (pin 15 is the low address bit in byte mode) |
| dq_out | output | DW (16) | Data pins, output side |
| dq_oe | output | DW (16) | Per-pin output enable |
| op | output | 3 | Current operation state code |
| rd_req | output | 1 | Array read request |
| rd_addr | output | AW (20) | Array word address |
| rd_data | input | DW (16) | Array word returned |
| cmd_stb | output | 1 | Single-cycle completed-write strobe |
| cmd_addr | output | AW (20) | Word address of the completed write |
| cmd_data | output | DW (16) | Data of the completed write |
| cmd_byte | output | 1 | Completed write was a byte write |
| cmd_upper | output | 1 | Byte write targets the high byte |

## Verification
A table of control patterns covers every case of the truth table. These include the read, disable and standby patterns, the pin reset overriding active read controls, and the both-low contention case. Each pattern tells apart the decodes that differ from it in one input. Byte-mode reads are run with pin 15 both low and high on the same address, which separates the lane choice from the address path. Writes are ended by `we_n`, by `ce_n` and by `prst_n`, which shows that only the first two strobe. A latency probe samples `op` one edge before and exactly at the documented delay.

// File: rtl/fbd_pkg.sv
package fbd_pkg;

    typedef enum logic [2:0] {
        OP_RESET   = 3'd0,
        OP_STANDBY = 3'd1,
        OP_DISABLE = 3'd2,
        OP_READ    = 3'd3,
        OP_WRITE   = 3'd4
    } op_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic prst_n;
        logic wide;
    } ctl_t;

    localparam int CTL_W = 5;

    // pins resting inactive: decodes as device reset
    localparam ctl_t CTL_IDLE = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1,
                                  prst_n: 1'b0, wide: 1'b1};

endpackage

// File: rtl/fbd_sync.sv
module fbd_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[0] <= RST_VAL;
                    else        stage_q[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[g] <= RST_VAL;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/fbd_decode.sv
module fbd_decode
    import fbd_pkg::*;
(
    input  ctl_t ctl,
    output op_e  op
);

    always_comb begin
        if (!ctl.prst_n)                       op = OP_RESET;
        else if (ctl.ce_n)                     op = OP_STANDBY;
        else if (!ctl.oe_n && ctl.we_n)        op = OP_READ;
        else if (ctl.oe_n && !ctl.we_n)        op = OP_WRITE;
        else                                   op = OP_DISABLE;
    end

endmodule

// File: rtl/fbd_rdpath.sv
module fbd_rdpath
    import fbd_pkg::*;
#(
    parameter int DW = 16
) (
    input  op_e           state,
    input  logic          wide,
    input  logic          upper,
    input  logic [DW-1:0] arr_data,
    output logic [DW-1:0] dq_out,
    output logic [DW-1:0] dq_oe
);

    localparam int HW = DW / 2;

    logic [HW-1:0] lane_sel;

    assign lane_sel = upper ? arr_data[DW-1:HW] : arr_data[HW-1:0];

    always_comb begin
        dq_out = '0;
        dq_oe  = '0;
        if (state == OP_READ) begin
            if (wide) begin
                dq_out = arr_data;
                dq_oe  = '1;
            end else begin
                dq_out[HW-1:0] = lane_sel;
                dq_oe[HW-1:0]  = '1;
            end
        end
    end

endmodule

// File: rtl/flash_bus_decoder.sv
module flash_bus_decoder
    import fbd_pkg::*;
#(
    parameter int AW          = 20,
    parameter int DW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          we_n,
    input  logic          prst_n,
    input  logic          wide,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] dq_in,
    output logic [DW-1:0] dq_out,
    output logic [DW-1:0] dq_oe,
    output logic [2:0]    op,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic [DW-1:0] rd_data,
    output logic          cmd_stb,
    output logic [AW-1:0] cmd_addr,
    output logic [DW-1:0] cmd_data,
    output logic          cmd_byte,
    output logic          cmd_upper
);

    localparam int HW     = DW / 2;
    localparam int PIPE_W = CTL_W + AW + DW;
    localparam logic [PIPE_W-1:0] PIPE_RST = {CTL_IDLE, {AW{1'b0}}, {DW{1'b0}}};

    ctl_t          pin_ctl;
    ctl_t          s_ctl;
    logic [AW-1:0] s_addr;
    logic [DW-1:0] s_dq;
    op_e           dec_op;
    op_e           state_q;

    logic          wide_q;
    logic          upper_q;
    logic [AW-1:0] rd_addr_q;

    logic [AW-1:0] hold_addr;
    logic [DW-1:0] hold_data;
    logic          hold_byte;
    logic          hold_upper;
    logic          stb_q;

    assign pin_ctl = '{ce_n: ce_n, oe_n: oe_n, we_n: we_n, prst_n: prst_n, wide: wide};

    fbd_sync #(
        .W      (PIPE_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(PIPE_RST)
    ) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({pin_ctl, addr, dq_in}),
        .q    ({s_ctl, s_addr, s_dq})
    );

    fbd_decode i_decode (
        .ctl(s_ctl),
        .op (dec_op)
    );

    // state register and the registers that travel with it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= OP_RESET;
            wide_q    <= 1'b1;
            upper_q   <= 1'b0;
            rd_addr_q <= '0;
        end else begin
            state_q   <= dec_op;
            wide_q    <= s_ctl.wide;
            upper_q   <= !s_ctl.wide && s_dq[DW-1];
            rd_addr_q <= s_addr;
        end
    end

    // write sample holding and end-of-write strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_addr  <= '0;
            hold_data  <= '0;
            hold_byte  <= 1'b0;
            hold_upper <= 1'b0;
            stb_q      <= 1'b0;
        end else begin
            if (dec_op == OP_WRITE) begin
                hold_addr  <= s_addr;
                hold_byte  <= !s_ctl.wide;
                hold_upper <= !s_ctl.wide && s_dq[DW-1];
                hold_data  <= s_ctl.wide ? s_dq : {{(DW-HW){1'b0}}, s_dq[HW-1:0]};
            end
            stb_q <= (state_q == OP_WRITE) && (dec_op != OP_WRITE) && (dec_op != OP_RESET);
        end
    end

    fbd_rdpath #(
        .DW(DW)
    ) i_rdpath (
        .state   (state_q),
        .wide    (wide_q),
        .upper   (upper_q),
        .arr_data(rd_data),
        .dq_out  (dq_out),
        .dq_oe   (dq_oe)
    );

    // output process
    always_comb begin
        op        = state_q;
        rd_req    = 1'b0;
        unique case (state_q)
            OP_READ:    rd_req = 1'b1;
            OP_RESET,
            OP_STANDBY,
            OP_DISABLE,
            OP_WRITE:   rd_req = 1'b0;
            default:    rd_req = 1'b0;
        endcase
        rd_addr   = rd_addr_q;
        cmd_stb   = stb_q;
        cmd_addr  = hold_addr;
        cmd_data  = hold_data;
        cmd_byte  = hold_byte;
        cmd_upper = hold_upper;
    end

endmodule

// File: rtl/fbd_chk.sv
module fbd_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    op,
    input logic          rd_req,
    input logic [DW-1:0] dq_oe,
    input logic          cmd_stb
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd0) |-> (dq_oe == '0 && !rd_req));

    // R5
    idle_tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op != 3'd3) |-> (dq_oe == '0));

    // R6
    read_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd3) |-> (dq_oe == '1 || dq_oe == {{(DW/2){1'b0}}, {(DW/2){1'b1}}}));

    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |=> !cmd_stb);

    // R3
    strobe_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_stb) |-> ($past(op) == 3'd4));

    // R4
    no_read_while_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb |-> (op != 3'd4));

endmodule

bind flash_bus_decoder fbd_chk #(.DW(DW)) i_fbd_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .op     (op),
    .rd_req (rd_req),
    .dq_oe  (dq_oe),
    .cmd_stb(cmd_stb)
);

// File: tb/test_flash_bus_decoder.sv
module test_flash_bus_decoder;

    localparam int AW = 20;
    localparam int DW = 16;
    localparam int SYNC_STAGES = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, prst_n = 1'b1, wide = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out, dq_oe, rd_data, cmd_data;
    logic [2:0]    op;
    logic          rd_req, cmd_stb, cmd_byte, cmd_upper;
    logic [AW-1:0] rd_addr, cmd_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int            pulses = 0;
    logic [AW-1:0] cap_addr;
    logic [DW-1:0] cap_data;
    logic          cap_byte, cap_upper;

    always #10 clk = ~clk;   // 50 MHz

    function automatic logic [DW-1:0] arr(input logic [AW-1:0] a);
        return a[15:0] ^ 16'h5A3C;
    endfunction

    assign rd_data = arr(rd_addr);

    flash_bus_decoder #(.AW(AW), .DW(DW), .SYNC_STAGES(SYNC_STAGES)) i_flash_bus_decoder (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .prst_n(prst_n), .wide(wide), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe), .op(op), .rd_req(rd_req),
        .rd_addr(rd_addr), .rd_data(rd_data), .cmd_stb(cmd_stb),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_byte(cmd_byte),
        .cmd_upper(cmd_upper)
    );

    always @(negedge clk) begin
        if (cmd_stb) begin
            pulses    <= pulses + 1;
            cap_addr  <= cmd_addr;
            cap_data  <= cmd_data;
            cap_byte  <= cmd_byte;
            cap_upper <= cmd_upper;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    typedef struct packed {
        logic          ce_n, oe_n, we_n, prst_n, wide;
        logic [19:0]   a;
        logic [15:0]   d;
        logic [2:0]    op;
        logic [15:0]   oe;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 20'h12345, 16'h0000, 3'd3, 16'hFFFF}, // R2 word read
        '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 20'h12345, 16'h0000, 3'd2, 16'h0000}, // R4 disable
        '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 20'h12345, 16'h0000, 3'd1, 16'h0000}, // R5 standby, oe low
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 20'h12345, 16'h0000, 3'd0, 16'h0000}, // R1 pin reset
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 20'h00ABC, 16'h0000, 3'd3, 16'h00FF}, // R6 byte lane low
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 20'h00ABC, 16'h8000, 3'd3, 16'h00FF}, // R6 byte lane high
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 20'h00001, 16'h0000, 3'd2, 16'h0000}, // R4 both low
        '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 20'h00001, 16'h0000, 3'd1, 16'h0000}  // R5 standby, both low
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        wait_neg(3);
        // R1 system reset state
        chk("R1 reset op", op, 3'd0);
        chk("R1 reset oe", dq_oe, 16'h0000);
        chk("R1 reset stb", cmd_stb, 1'b0);
        rst_n = 1'b1;
        wait_neg(5);

        for (int i = 0; i < NV; i++) begin
            logic [DW-1:0] exp_out;
            ce_n = VECS[i].ce_n; oe_n = VECS[i].oe_n; we_n = VECS[i].we_n;
            prst_n = VECS[i].prst_n; wide = VECS[i].wide;
            addr = VECS[i].a; dq_in = VECS[i].d;
            wait_neg(SYNC_STAGES + 3);
            chk($sformatf("R1-5 vec%0d op", i), op, VECS[i].op);
            chk($sformatf("R2/R6 vec%0d oe", i), dq_oe, VECS[i].oe);
            chk($sformatf("R2 vec%0d rd_req", i), rd_req, VECS[i].op == 3'd3);
            exp_out = '0;
            if (VECS[i].op == 3'd3) begin
                if (VECS[i].wide) exp_out = arr(VECS[i].a);
                else if (VECS[i].d[15]) exp_out = {8'h00, arr(VECS[i].a)[15:8]};
                else exp_out = {8'h00, arr(VECS[i].a)[7:0]};
                chk($sformatf("R2 vec%0d rd_addr", i), rd_addr, VECS[i].a);
            end
            chk($sformatf("R6 vec%0d dq_out", i), dq_out, exp_out);
            chk($sformatf("R4 vec%0d no strobe", i), pulses, 0);
        end

        // R9 latency: from disable to read
        ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; prst_n = 1'b1; wide = 1'b1;
        wait_neg(6);
        oe_n = 1'b0;
        wait_neg(SYNC_STAGES);
        chk("R9 before latency", op, 3'd2);
        wait_neg(1);
        chk("R9 at latency", op, 3'd3);

        // R3 word write ended by we_n
        oe_n = 1'b1; wait_neg(4);
        addr = 20'hBEEF1; dq_in = 16'hC0DE; we_n = 1'b0;
        wait_neg(SYNC_STAGES + 2);
        chk("R3 write op", op, 3'd4);
        chk("R3 write oe", dq_oe, 16'h0000);
        we_n = 1'b1;
        wait_neg(8);
        chk("R8 one pulse", pulses, 1);
        chk("R3 addr", cap_addr, 20'hBEEF1);
        chk("R3 data", cap_data, 16'hC0DE);
        chk("R7 word byte flag", {cap_byte, cap_upper}, 2'b00);

        // R7 byte write, upper lane, ended by ce_n
        wide = 1'b0; addr = 20'h00321; dq_in = 16'h80A7; we_n = 1'b0;
        wait_neg(SYNC_STAGES + 2);
        ce_n = 1'b1;
        wait_neg(8);
        chk("R8 second pulse", pulses, 2);
        chk("R7 byte data", cap_data, 16'h00A7);
        chk("R7 byte flags", {cap_byte, cap_upper}, 2'b11);
        chk("R7 byte addr", cap_addr, 20'h00321);

        // R8 write cut by pin reset: no strobe
        ce_n = 1'b0; wide = 1'b1; we_n = 1'b0; dq_in = 16'h1111;
        wait_neg(SYNC_STAGES + 2);
        prst_n = 1'b0;
        wait_neg(8);
        chk("R8 reset abort", pulses, 2);
        chk("R1 reset over write", op, 3'd0);

        done = 1;
        summary();
    end

endmodule